// File: doc/BRIEF.md
# Decade Rate Divider with Tap Selector

The block turns one 10 MHz reference clock into seven lower rates, each ten times slower than the one before it: 1 MHz, 100 kHz, 10 kHz, 1 kHz, 100 Hz, 10 Hz and 1 Hz. A 3-bit select input picks one of these rates and drives it to a single square-wave output.

All the counting happens on the reference clock, so the block has no ripple clocking. Each decade stage is a counter from 0 to 9. It advances only in cycles where every faster stage is at its terminal count. Each stage owns a flip-flop that holds its tap. The tap is high while the stage count is between 5 and 9, so it has a 50 % duty cycle. The select code is captured in a register before it steers the output multiplexer, and the output itself is also registered. Decode glitches and select changes therefore reach the output only on a clock edge.

Top module: `decade_divider_select`

## Requirements
- R1: Stage 0 advances on every clock edge while reset is released, and every stage count stays within 0..9.
- R2: Stage k (k ≥ 1) advances only on an edge where all stages 0..k-1 are at 9. A stage at 9 that advances wraps to 0.
- R3: With select code k held, the output is periodic with a period of 10^(k+1) reference cycles. Code 0 gives a 10-cycle period and code 3 gives a 10,000-cycle period.
- R4: Tap k is high exactly while stage k is in counts 5..9, so the output is high for half of each period (5·10^k cycles).
- R5: Select codes 0..6 choose taps 0..6 in that order, from fastest (1 MHz) to slowest (1 Hz).
- R6: Select code 7 drives the output low whatever the taps are doing.
- R7: The select input is registered. A code applied before edge E steers the output from edge E+1 onward, and the output after edge E+1 shows the value the selected tap held after edge E.
- R8: Reset is synchronous and active low. It clears all stages, taps, the select register and the output, and the output stays 0 while reset is held. After release with code k, the first rising output edge appears on clock edge 5·10^k + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (10 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 3 | Tap select: 0..6 = 1 MHz..1 Hz, 7 = output low |
| div_o | output | 1 | Registered square wave of the selected tap |

## Verification
The stage assertions assume that the reference clock runs continuously and that reset is only released on a clock boundary. The bench meets this by changing rst_n and sel_i only on falling edges. The select assertions accept any 3-bit code on any cycle, including code 7 and back-to-back changes, and the random phase uses all of these freely. The bench's edge-accurate model of the expected output depends only on the edge count since reset, so every test starts from a fresh reset. Because of this, period and duty are measured directly only for the taps whose periods fit in the run. For tap 4, only its first rising edge is timed.

// File: rtl/decdiv_pkg.sv
// Package decdiv_pkg
// Shared constants for the decade divider. Assumes an even radix so that
// the tap duty cycle is exactly one half.
package decdiv_pkg;
    localparam int unsigned DEF_RADIX  = 10;
    localparam int unsigned DEF_STAGES = 7;

    // Width of a select code able to name every stage plus one "off" code.
    function automatic int unsigned sel_width(input int unsigned stages);
        return $clog2(stages + 1);
    endfunction
endpackage

// File: rtl/decdiv_stage.sv
// Module decdiv_stage
// One modulo-RADIX counter with a registered half-period tap. It advances
// only when adv_i is high, and it raises carry_o combinationally in the
// advancing cycle in which it sits at its last count. Assumes RADIX is even
// and at least 2.
module decdiv_stage #(
    parameter int unsigned RADIX = decdiv_pkg::DEF_RADIX,
    localparam int unsigned CNT_W = $clog2(RADIX)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic carry_o,
    output logic tap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RADIX - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(RADIX / 2);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             tap_q;

    // Next count: hold, step, or wrap at the last count.
    always_comb begin
        cnt_d = cnt_q;
        if (adv_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Count and tap registers, both cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tap_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            tap_q <= (cnt_d >= HALF);
        end
    end

    // Enable for the next slower stage.
    assign carry_o = adv_i && (cnt_q == LAST);
    assign tap_o   = tap_q;

    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && cnt_q == LAST) |=> (cnt_q == '0));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_q));
    p_tap_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q == (cnt_q >= HALF));
    p_tap_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(tap_q));
endmodule

// File: rtl/decdiv_tap_mux.sv
// Module decdiv_tap_mux
// Captures the select code in a register, then picks one tap into a
// registered output. Any code of NUM or more gives a low output. Assumes
// the taps are register outputs from the same clock.
module decdiv_tap_mux #(
    parameter int unsigned NUM   = decdiv_pkg::DEF_STAGES,
    parameter int unsigned SEL_W = decdiv_pkg::sel_width(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NUM-1:0]   taps_i,
    output logic             out_o
);
    logic [SEL_W-1:0] sel_q;
    logic             pick;
    logic             out_q;

    // Select register, so that code changes enter on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_i;
    end

    // Tap choice by code; codes beyond the last tap give zero.
    always_comb begin
        pick = 1'b0;
        for (int unsigned i = 0; i < NUM; i++) begin
            if (sel_q == SEL_W'(i)) pick = taps_i[i];
        end
    end

    // Output register, so that only registered state reaches the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= pick;
    end

    assign out_o = out_q;

    p_sel_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel_q == $past(sel_i)));
    p_off_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q >= SEL_W'(NUM)) |=> !out_q);
    p_fast_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |=> (out_q == $past(taps_i[0])));
    p_reset_low_r8: assert property (@(posedge clk)
        !rst_n |=> !out_q);
endmodule

// File: rtl/decade_divider_select.sv
// Module decade_divider_select
// A chain of NUM_STAGES decade stages on a single clock, with one selectable
// registered output. Stage 0 advances every cycle. Stage k+1 advances when
// stage k raises its carry. Assumes one free-running reference clock.
module decade_divider_select #(
    parameter int unsigned NUM_STAGES = decdiv_pkg::DEF_STAGES,
    parameter int unsigned RADIX      = decdiv_pkg::DEF_RADIX,
    parameter int unsigned SEL_W      = decdiv_pkg::sel_width(NUM_STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             div_o
);
    logic [NUM_STAGES:0]   adv;
    logic [NUM_STAGES-1:0] taps;

    assign adv[0] = 1'b1;

    // One stage per decade, chained by carry enables.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        decdiv_stage #(.RADIX(RADIX)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv_i   (adv[g]),
            .carry_o (adv[g+1]),
            .tap_o   (taps[g])
        );
    end

    decdiv_tap_mux #(.NUM(NUM_STAGES), .SEL_W(SEL_W)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_i),
        .taps_i (taps),
        .out_o  (div_o)
    );

    p_first_stage_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adv[0]);
    p_carry_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv[NUM_STAGES] |-> adv[1]);
endmodule

// File: tb/decade_divider_select_test.sv
module decade_divider_select_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       div_o;

    int unsigned errors = 0;
    int unsigned checks = 0;
    bit          done = 1'b0;
    bit          chk_en = 1'b0;

    // Bench model state: edges since reset, select copy, expected output.
    longint unsigned ncyc = 0;
    logic [2:0]      selm = 3'd0;
    logic            expo = 1'b0;

    always #5 clk = ~clk;

    decade_divider_select uut (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel),
        .div_o (div_o)
    );

    function automatic longint unsigned pow10(input int unsigned k);
        longint unsigned p = 1;
        for (int unsigned i = 0; i < k; i++) p = p * 10;
        return p;
    endfunction

    // Expected tap k after m counting edges: high for digit 5..9 (R4).
    function automatic logic tap_exp(input int unsigned k, input longint unsigned m);
        return ((m / pow10(k)) % 10) >= 5;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ncyc <= 0;
            selm <= 3'd0;
            expo <= 1'b0;
        end else begin
            ncyc <= ncyc + 1;
            selm <= sel;
            expo <= (selm < 3'd7) ? tap_exp(selm, ncyc) : 1'b0;
        end
    end

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Edge-accurate model comparison covering R1, R2, R5, R6, R7.
    always @(negedge clk) begin
        if (chk_en && !done) check("R5 R6 R7 model", div_o, expo);
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        sel = code;
        repeat (3) begin
            @(negedge clk);
            check("R8 low in reset", div_o, 0);
        end
        rst_n = 1'b1;
    endtask

    // First rise, high time and period for code k (R3, R4, R8).
    task automatic measure(input int unsigned k, input bit full);
        longint unsigned n = 0, h = 0, l = 0;
        do_reset(3'(k));
        do begin @(negedge clk); n++; end while (div_o !== 1'b1);
        check("R8 first rise", n, 5 * pow10(k) + 1);
        if (full) begin
            while (div_o === 1'b1) begin @(negedge clk); h++; end
            while (div_o === 1'b0) begin @(negedge clk); l++; end
            check("R4 high time", h, 5 * pow10(k));
            check("R3 period", h + l, pow10(k + 1));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        chk_en = 1'b1;
        check("R8 reset output", div_o, 0);

        for (int unsigned k = 0; k < 4; k++) measure(k, 1'b1);
        measure(4, 1'b0);

        // Off code held: output must stay low (R6).
        do_reset(3'd7);
        repeat (200) begin
            @(negedge clk);
            check("R6 off code low", div_o, 0);
        end

        // Directed latency case (R7): switch 7 -> 0 while tap 0 is high.
        while (!tap_exp(0, ncyc)) @(negedge clk);
        sel = 3'd0;
        @(negedge clk);
        check("R7 one edge later", div_o, 0);
        @(negedge clk);
        check("R7 two edges later", div_o, 1);

        // Random select codes, compared every cycle by the model (R5, R6, R7).
        do_reset(3'd0);
        repeat (300) begin
            sel = 3'($urandom % 8);
            repeat (1 + ($urandom % 12)) @(negedge clk);
        end

        // Reset in mid count, then restart on code 1 (R8).
        measure(1, 1'b1);
        finish_run();
    end
endmodule